// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block lets several requesters (hardware threads or ports) build atomic read-modify-write sequences from two separate accesses instead of one locked bus operation. Each requester owns one reservation slot. A load-linked access records which memory word the requester read and marks the slot valid. A later store-conditional from the same requester is allowed to reach memory only while that slot is still valid and still names the same word. The block tells the requester whether the conditional store went through, so software can loop until it does.

Reservations die on several events. The owner's own conditional store removes its reservation whether or not it wins. Any store that actually reaches memory removes every reservation on the word it writes. This covers plain stores and winning conditional stores from any requester. A single external clear drops every reservation at once, for example on an exception. When more than one conditional store to the same word arrives in the same cycle, a fixed priority picks exactly one winner. All decisions are combinational on the request cycle. The reservation state changes at the next clock edge.

Top module: `llsc_monitor`

## Requirements
- R1: After reset no requester holds a reservation, so a store-conditional (op code 2'b10) issued right after reset fails and is not granted.
- R2: A load-linked (op code 2'b01) to a word followed by a store-conditional from the same requester to that word, with nothing in between that kills it, drives both `wr_grant` and `sc_success` high for that requester in the cycle of the store-conditional.
- R3: A store-conditional whose requester has no valid reservation, or whose word differs from the reserved word, gives `sc_success` 0 and `wr_grant` 0.
- R4: Matching is done on aligned words of GRAN_BYTES bytes (4 by default): only address bits above the low log2(GRAN_BYTES) bits are compared, so any byte inside the reserved word matches.
- R5: A requester's own store-conditional clears its reservation whether it succeeds or fails, so a second store-conditional to the same word without a new load-linked fails.
- R6: A new load-linked by a requester replaces its earlier reservation; only the most recent word can then succeed.
- R7: A successful store-conditional by one requester clears the reservations that other requesters hold on the same word.
- R8: A plain store (op code 2'b11) from any requester clears every reservation on the written word and leaves reservations on other words intact.
- R9: When several store-conditionals that would each succeed target the same word in one cycle, only the lowest-numbered requester succeeds and is granted; the others fail.
- R10: Asserting `clr_all` for one cycle invalidates every reservation at the next edge, and it overrides a load-linked issued in the same cycle.
- R11: A plain store is always granted (`wr_grant` 1) and never reports `sc_success`; load-linked and idle (op code 2'b00) cycles give `wr_grant` 0 and `sc_success` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_all | input | 1 | Drops all reservations at the next edge |
| req_op | input | 2*NUM_REQ | Per-requester op: 00 idle, 01 load-linked, 10 store-conditional, 11 plain store; requester i at bits [2i+1:2i] |
| req_addr | input | ADDR_W*NUM_REQ | Per-requester byte address; requester i at bits [ADDR_W*i +: ADDR_W] |
| wr_grant | output | NUM_REQ | Store of requester i may be written to memory this cycle |
| sc_success | output | NUM_REQ | Store-conditional of requester i succeeded this cycle (result value 1) |

## Verification
A slot that holds a stale valid bit or a wrong word stays hidden until its owner issues a store-conditional. At that point it shows as a wrong `sc_success` and `wr_grant` in that same cycle. The bench therefore follows every reservation-changing event closely with store-conditionals. A missed clear from another requester's write is only visible when the victim's store-conditional wins when it should fail. Broken same-cycle arbitration shows at once as two success bits on one word.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

   typedef enum logic [1:0] {
      OP_IDLE = 2'b00,
      OP_LL   = 2'b01,
      OP_SC   = 2'b10,
      OP_ST   = 2'b11
   } llsc_op_e;

endpackage

// File: rtl/llsc_arbiter.sv
// Same-cycle conflict resolution among store-conditional candidates
module llsc_arbiter #(
   parameter int NUM_REQ   = 4,
   parameter int TAG_W     = 30,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic [NUM_REQ-1:0]       cand,
   input  logic [NUM_REQ*TAG_W-1:0] cand_tag,
   output logic [NUM_REQ-1:0]       win
);

   for (genvar i = 0; i < NUM_REQ; i++) begin : g_req
      logic blocked;
      if (LOW_FIRST) begin : g_low
         always_comb begin
            blocked = 1'b0;
            for (int j = 0; j < i; j++) begin
               if (cand[j] && (cand_tag[j*TAG_W +: TAG_W] == cand_tag[i*TAG_W +: TAG_W]))
                  blocked = 1'b1;
            end
         end
      end else begin : g_high
         always_comb begin
            blocked = 1'b0;
            for (int j = i + 1; j < NUM_REQ; j++) begin
               if (cand[j] && (cand_tag[j*TAG_W +: TAG_W] == cand_tag[i*TAG_W +: TAG_W]))
                  blocked = 1'b1;
            end
         end
      end
      assign win[i] = cand[i] & ~blocked;
   end

endmodule

// File: rtl/llsc_slot.sv
// One reservation: valid bit plus word tag, with set / consume / snoop-kill rules
module llsc_slot #(
   parameter int NUM_REQ = 4,
   parameter int TAG_W   = 30
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr_all,
   input  logic                     own_ll,
   input  logic                     own_sc,
   input  logic [TAG_W-1:0]         own_tag,
   input  logic [NUM_REQ-1:0]       wr_en,
   input  logic [NUM_REQ*TAG_W-1:0] wr_tag,
   output logic                     rsv_vld,
   output logic [TAG_W-1:0]         rsv_tag
);

   logic snoop_hit;

   always_comb begin
      snoop_hit = 1'b0;
      for (int j = 0; j < NUM_REQ; j++) begin
         if (wr_en[j] && (wr_tag[j*TAG_W +: TAG_W] == rsv_tag))
            snoop_hit = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsv_vld <= 1'b0;
         rsv_tag <= '0;
      end else if (clr_all) begin
         rsv_vld <= 1'b0;
      end else if (own_ll) begin
         rsv_vld <= 1'b1;
         rsv_tag <= own_tag;
      end else if (own_sc) begin
         rsv_vld <= 1'b0;
      end else if (snoop_hit) begin
         rsv_vld <= 1'b0;
      end
   end

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
   import llsc_pkg::*;
#(
   parameter int NUM_REQ    = 4,
   parameter int ADDR_W     = 32,
   parameter int GRAN_BYTES = 4,
   parameter bit LOW_FIRST  = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clr_all,
   input  logic [2*NUM_REQ-1:0]      req_op,
   input  logic [ADDR_W*NUM_REQ-1:0] req_addr,
   output logic [NUM_REQ-1:0]        wr_grant,
   output logic [NUM_REQ-1:0]        sc_success
);

   localparam int OFS_W = $clog2(GRAN_BYTES);
   localparam int TAG_W = ADDR_W - OFS_W;

   if (NUM_REQ < 1) begin : g_bad_req
      $error("llsc_monitor: NUM_REQ must be at least 1");
   end
   if (GRAN_BYTES < 2 || (GRAN_BYTES & (GRAN_BYTES - 1)) != 0) begin : g_bad_gran
      $error("llsc_monitor: GRAN_BYTES must be a power of two of at least 2");
   end
   if (OFS_W >= ADDR_W) begin : g_bad_addr
      $error("llsc_monitor: ADDR_W too small for GRAN_BYTES");
   end

   logic [NUM_REQ-1:0]       is_ll, is_sc, is_st;
   logic [NUM_REQ*TAG_W-1:0] req_tag;
   logic [NUM_REQ-1:0]       slot_vld;
   logic [NUM_REQ*TAG_W-1:0] slot_tag;
   logic [NUM_REQ-1:0]       cand, win, wr_en;
   logic [NUM_REQ*OFS_W-1:0] unused_ofs_bits;

   for (genvar i = 0; i < NUM_REQ; i++) begin : g_dec
      llsc_op_e op;
      assign op = llsc_op_e'(req_op[2*i +: 2]);
      assign is_ll[i] = (op == OP_LL);
      assign is_sc[i] = (op == OP_SC);
      assign is_st[i] = (op == OP_ST);
      assign req_tag[i*TAG_W +: TAG_W]         = req_addr[i*ADDR_W + OFS_W +: TAG_W];
      assign unused_ofs_bits[i*OFS_W +: OFS_W] = req_addr[i*ADDR_W +: OFS_W];
      assign cand[i] = is_sc[i] & slot_vld[i] &
                       (slot_tag[i*TAG_W +: TAG_W] == req_tag[i*TAG_W +: TAG_W]);
   end

   llsc_arbiter #(
      .NUM_REQ  (NUM_REQ),
      .TAG_W    (TAG_W),
      .LOW_FIRST(LOW_FIRST)
   ) u_arb (
      .cand    (cand),
      .cand_tag(req_tag),
      .win     (win)
   );

   assign wr_en      = is_st | win;
   assign wr_grant   = wr_en;
   assign sc_success = win;

   for (genvar i = 0; i < NUM_REQ; i++) begin : g_slot
      llsc_slot #(
         .NUM_REQ(NUM_REQ),
         .TAG_W  (TAG_W)
      ) u_slot (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr_all(clr_all),
         .own_ll (is_ll[i]),
         .own_sc (is_sc[i]),
         .own_tag(req_tag[i*TAG_W +: TAG_W]),
         .wr_en  (wr_en),
         .wr_tag (req_tag),
         .rsv_vld(slot_vld[i]),
         .rsv_tag(slot_tag[i*TAG_W +: TAG_W])
      );
   end

endmodule

// File: rtl/llsc_monitor_sva.sv
module llsc_monitor_sva #(
   parameter int NUM_REQ    = 4,
   parameter int ADDR_W     = 32,
   parameter int GRAN_BYTES = 4
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      clr_all,
   input logic [2*NUM_REQ-1:0]      req_op,
   input logic [ADDR_W*NUM_REQ-1:0] req_addr,
   input logic [NUM_REQ-1:0]        wr_grant,
   input logic [NUM_REQ-1:0]        sc_success
);

   localparam int OFS_W = $clog2(GRAN_BYTES);
   localparam int TAG_W = ADDR_W - OFS_W;

   // R10: nothing can succeed right after a global clear
   a_r10_clear_kills_all: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all |=> (sc_success == '0));

   for (genvar i = 0; i < NUM_REQ; i++) begin : g_one
      logic [TAG_W-1:0] w_i;
      assign w_i = req_addr[i*ADDR_W + OFS_W +: TAG_W];

      // R3: success only for a store-conditional, and always with a grant
      a_r3_success_is_granted_sc: assert property (@(posedge clk) disable iff (!rst_n)
         sc_success[i] |-> (wr_grant[i] && req_op[2*i +: 2] == 2'b10));

      // R11: plain store always granted, never a success
      a_r11_plain_store_granted: assert property (@(posedge clk) disable iff (!rst_n)
         (req_op[2*i +: 2] == 2'b11) |-> (wr_grant[i] && !sc_success[i]));

      // R5: a store-conditional consumes the reservation
      a_r5_sc_consumes: assert property (@(posedge clk) disable iff (!rst_n)
         (req_op[2*i +: 2] == 2'b10) |=> !sc_success[i]);

      for (genvar j = 0; j < NUM_REQ; j++) begin : g_pair
         if (j > i) begin : g_gt
            logic [TAG_W-1:0] w_j;
            assign w_j = req_addr[j*ADDR_W + OFS_W +: TAG_W];
            // R9: at most one winner per word per cycle
            a_r9_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
               (sc_success[i] && sc_success[j]) |-> (w_i != w_j));
         end
         if (j != i) begin : g_ne
            logic [TAG_W-1:0] w_jx;
            assign w_jx = req_addr[j*ADDR_W + OFS_W +: TAG_W];
            // R7: a winner kills other reservations on its word
            a_r7_winner_kills_others: assert property (@(posedge clk) disable iff (!rst_n)
               (sc_success[i] && req_op[2*j +: 2] != 2'b01) |=>
                  !(sc_success[j] && w_jx == $past(w_i)));
         end
      end
   end

endmodule

bind llsc_monitor llsc_monitor_sva #(
   .NUM_REQ   (NUM_REQ),
   .ADDR_W    (ADDR_W),
   .GRAN_BYTES(GRAN_BYTES)
) u_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .clr_all   (clr_all),
   .req_op    (req_op),
   .req_addr  (req_addr),
   .wr_grant  (wr_grant),
   .sc_success(sc_success)
);

// File: tb/llsc_monitor_tb.sv
module llsc_monitor_tb;

   localparam int NR = 4;
   localparam int AW = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              clr_all = 1'b0;
   logic [2*NR-1:0]   req_op = '0;
   logic [AW*NR-1:0]  req_addr = '0;
   logic [NR-1:0]     wr_grant, sc_success;

   int checks = 0;
   int fails  = 0;

   // reference state
   bit             m_vld [NR];
   int unsigned    m_word[NR];

   always #4 clk = ~clk;

   llsc_monitor #(.NUM_REQ(NR), .ADDR_W(AW), .GRAN_BYTES(4), .LOW_FIRST(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .clr_all(clr_all),
      .req_op(req_op), .req_addr(req_addr),
      .wr_grant(wr_grant), .sc_success(sc_success)
   );

   task automatic put(input int r, input logic [1:0] op, input logic [31:0] a);
      req_op[2*r +: 2]    = op;
      req_addr[AW*r +: AW] = a;
   endtask

   task automatic idle_all();
      req_op  = '0;
      clr_all = 1'b0;
   endtask

   task automatic step(input string tag, input bit use_exp, input logic [NR-1:0] exp_sc);
      logic [NR-1:0] e_gnt, e_sc;
      bit cand[NR];
      @(negedge clk);
      for (int i = 0; i < NR; i++)
         cand[i] = (req_op[2*i +: 2] == 2'b10) && m_vld[i] &&
                   (m_word[i] == (req_addr[AW*i +: AW] >> 2));
      for (int i = 0; i < NR; i++) begin
         bit beaten = 0;
         for (int j = 0; j < i; j++)
            if (cand[j] && ((req_addr[AW*j +: AW] >> 2) == (req_addr[AW*i +: AW] >> 2)))
               beaten = 1;
         e_sc[i]  = cand[i] && !beaten;
         e_gnt[i] = e_sc[i] || (req_op[2*i +: 2] == 2'b11);
      end
      checks++;
      if (wr_grant !== e_gnt || sc_success !== e_sc) begin
         fails++;
         $display("FAIL %s: grant=%b success=%b expected grant=%b success=%b",
                  tag, wr_grant, sc_success, e_gnt, e_sc);
      end
      if (use_exp) begin
         checks++;
         if (sc_success !== exp_sc) begin
            fails++;
            $display("FAIL %s: success=%b expected %b", tag, sc_success, exp_sc);
         end
      end
      // advance reference state to the next edge
      begin
         bit killed[NR];
         for (int k = 0; k < NR; k++) begin
            killed[k] = 0;
            for (int j = 0; j < NR; j++)
               if (e_gnt[j] && ((req_addr[AW*j +: AW] >> 2) == m_word[k])) killed[k] = 1;
         end
         for (int k = 0; k < NR; k++) begin
            if (clr_all) m_vld[k] = 0;
            else if (req_op[2*k +: 2] == 2'b01) begin
               m_vld[k]  = 1;
               m_word[k] = req_addr[AW*k +: AW] >> 2;
            end else if (req_op[2*k +: 2] == 2'b10) m_vld[k] = 0;
            else if (killed[k]) m_vld[k] = 0;
         end
      end
      @(posedge clk);
      #1;
      idle_all();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < NR; i++) begin m_vld[i] = 0; m_word[i] = 0; end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: nothing reserved after reset
      for (int i = 0; i < NR; i++) put(i, 2'b10, 32'h100);
      step("R1 sc after reset", 1, 4'b0000);

      // R2: basic pair
      put(0, 2'b01, 32'h100); step("R2 ll", 1, 4'b0000);
      put(0, 2'b10, 32'h100); step("R2 sc success", 1, 4'b0001);
      // R5: consumed by success
      put(0, 2'b10, 32'h100); step("R5 second sc", 1, 4'b0000);

      // R4: byte within word matches
      put(1, 2'b01, 32'h200); step("R4 ll", 0, '0);
      put(1, 2'b10, 32'h203); step("R4 sc other byte", 1, 4'b0010);

      // R3: wrong word fails, R5: failed sc still consumes
      put(2, 2'b01, 32'h300); step("R3 ll", 0, '0);
      put(2, 2'b10, 32'h304); step("R3 sc wrong word", 1, 4'b0000);
      put(2, 2'b10, 32'h300); step("R5 sc after failed sc", 1, 4'b0000);

      // R6: replacement
      put(3, 2'b01, 32'h400); step("R6 ll a", 0, '0);
      put(3, 2'b01, 32'h500); step("R6 ll b", 0, '0);
      put(3, 2'b10, 32'h400); step("R6 sc old word", 1, 4'b0000);
      put(3, 2'b01, 32'h500); step("R6 ll b again", 0, '0);
      put(3, 2'b10, 32'h500); step("R6 sc new word", 1, 4'b1000);

      // R7: winner kills others
      put(0, 2'b01, 32'h600); put(1, 2'b01, 32'h600); step("R7 ll both", 0, '0);
      put(0, 2'b10, 32'h600); step("R7 sc winner", 1, 4'b0001);
      put(1, 2'b10, 32'h600); step("R7 sc loser", 1, 4'b0000);

      // R8 / R11: plain store kills only its word
      put(0, 2'b01, 32'h700); put(1, 2'b01, 32'h800); step("R8 ll", 0, '0);
      put(2, 2'b11, 32'h702); step("R11 plain store granted", 1, 4'b0000);
      put(0, 2'b10, 32'h700); put(1, 2'b10, 32'h800); step("R8 sc after store", 1, 4'b0010);

      // R9: same-cycle race
      put(1, 2'b01, 32'h900); put(2, 2'b01, 32'h900); put(3, 2'b01, 32'h900);
      step("R9 ll three", 0, '0);
      put(1, 2'b10, 32'h900); put(2, 2'b10, 32'h901); put(3, 2'b10, 32'h902);
      step("R9 race", 1, 4'b0010);

      // R10: global clear, overriding a same-cycle ll
      put(0, 2'b01, 32'hA00); put(1, 2'b01, 32'hB00); step("R10 ll", 0, '0);
      put(2, 2'b01, 32'hC00); clr_all = 1'b1; step("R10 clear", 0, '0);
      put(0, 2'b10, 32'hA00); put(1, 2'b10, 32'hB00); put(2, 2'b10, 32'hC00);
      step("R10 sc after clear", 1, 4'b0000);

      // mixed traffic on a few words, compared against the reference every cycle
      for (int n = 0; n < 3000; n++) begin
         for (int i = 0; i < NR; i++)
            put(i, 2'($urandom_range(0, 3)), 32'h1000 + 32'($urandom_range(0, 11)));
         clr_all = ($urandom_range(0, 63) == 0);
         step("R2-R10 mixed", 0, '0);
      end

      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

endmodule